// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

A single DMA channel that copies data, one item per request pulse, between a fixed peripheral data address and a local RAM holding two buffers. Software programs the buffer start addresses, the peripheral address, a transfer count and a 16-bit control word through a small register port, then sets the enable bit. Each request then produces a two-cycle transfer. In the first cycle the source is read, and in the second cycle the destination is written with the returned data.

The control word selects these behaviours:
- the direction of the copy;
- byte or word items;
- how the RAM address is formed: stepped, held fixed, or supplied by the peripheral;
- one-shot or continuous operation, each with or without alternation between the two buffers;
- whether the block interrupt fires at the half-way point or at the end of the block;
- an extra zero-data write to the peripheral that goes along with every RAM write.

The block interrupt is a one-cycle pulse. A separate output shows which buffer is active.

Top module: `dma_chan_seq`

## Requirements
- R1: Register port offsets are 0 for control, 1 for buffer A start, 2 for buffer B start, 3 for peripheral address and 4 for count. Reads are combinational.
  - The control word holds enable at bit 15, byte size at 14, direction at 13, half select at 12, null write at 11, addressing mode at 5:4 and operating mode at 1:0.
  - All other control bits read 0.
  - Every register resets to 0.
- R2: While enable is 0, requests are ignored and no read or write strobe is raised.
- R3: With direction 0, the sequence is as follows.
  - A request sampled at clock edge k raises `per_re` at `per_addr` in the cycle after edge k.
  - `ram_we` is raised in the following cycle, with `ram_wdata` equal to the `per_rdata` returned in that cycle.
- R4: With direction 1, the same two cycles raise `ram_re` and then `per_we`, with `per_wdata` equal to `ram_rdata`.
- R5: For the transfer size, bit 14 selects between two behaviours.
  - When bit 14 is 1 (byte), the written data keeps only bits 7:0 and the upper byte is 0. After each transfer, addressing mode 00 steps the RAM address by 1.
  - When bit 14 is 0 (word), the full 16 bits are moved and the step is 2.
- R6: Addressing mode 01 keeps the RAM address fixed. Modes 10 and 11 drive `ram_addr` from the `per_ram_addr` input.
- R7: With null write set and direction 0, each RAM write is accompanied by a `per_we` to `per_addr` with data 0. With direction 1, null write changes nothing.
- R8: A block is count+1 transfers. When half select is 0, `irq` is high for exactly one cycle, the cycle after the write of the last transfer of a block.
- R9: When half select is 1, `irq` pulses instead after transfer floor((count+1)/2), with a minimum of 1, and not at the end of the block.
- R10: In operating mode 01 (one-shot), the channel clears its enable bit when the block completes.
- R11: In operating mode 00 (continuous), the channel stays enabled after a block. The next block restarts at buffer A's start address.
- R12: Operating modes 10 and 11 alternate between the two buffers.
  - The channel starts on buffer A, and `active_buf` shows the active buffer, with 0 meaning A.
  - At every block end the channel switches buffer and reloads that buffer's start address.
  - Mode 11 clears enable at the end of the buffer-B block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| xfer_req | input | 1 | Peripheral request pulse; ignored while a transfer is under way |
| active_buf | output | 1 | Active buffer (0 = A, 1 = B) |
| irq | output | 1 | Block interrupt pulse |
| xfer_byte | output | 1 | High when items are bytes |
| ram_addr | output | AW | RAM address |
| ram_re | output | 1 | RAM read strobe; data expected the next cycle |
| ram_we | output | 1 | RAM write strobe |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data |
| per_addr | output | AW | Peripheral data address |
| per_re | output | 1 | Peripheral read strobe; data expected the next cycle |
| per_we | output | 1 | Peripheral write strobe |
| per_wdata | output | 16 | Peripheral write data |
| per_rdata | input | 16 | Peripheral read data |
| per_ram_addr | input | AW | RAM address supplied by the peripheral |

## Verification
Transfers are run in both directions with word and byte items. The peripheral model returns a changing sequence value and the RAM model returns a value derived from the address, so a stale, swapped or unmasked data path shows up as a wrong value. The three addressing modes are compared on the same request stream, which separates stepping by 1 or 2 from a fixed address and from the address supplied by the peripheral. Block lengths of 1, 2, 4, 5 and 6 transfers, with and without half select, place the interrupt pulse on one specific transfer. Each of the four operating modes is run over more than one block, and this distinguishes a reload, a buffer swap and self-disable from one another.

// File: rtl/dma_chan_seq.sv
module dma_chan_seq #(
  parameter int AW = 16,
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  input  logic          xfer_req,
  output logic          active_buf,
  output logic          irq,
  output logic          xfer_byte,
  output logic [AW-1:0] ram_addr,
  output logic          ram_re,
  output logic          ram_we,
  output logic [15:0]   ram_wdata,
  input  logic [15:0]   ram_rdata,
  output logic [AW-1:0] per_addr,
  output logic          per_re,
  output logic          per_we,
  output logic [15:0]   per_wdata,
  input  logic [15:0]   per_rdata,
  input  logic [AW-1:0] per_ram_addr
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WR} st_t;

  st_t st;
  logic en, sz, dir, half, nullw;
  logic [1:0] amode, mode;
  logic [AW-1:0] sta_a, sta_b, padr, cur;
  logic [CW-1:0] cnt;
  logic [CW:0] done;
  logic bsel;

  logic [CW:0] blk, hp, dn;
  logic last;
  logic [15:0] ctl;

  assign blk  = {1'b0, cnt} + 1'b1;
  assign hp   = ((blk >> 1) == '0) ? {{CW{1'b0}}, 1'b1} : (blk >> 1);
  assign dn   = done + 1'b1;
  assign last = (dn == blk);
  assign ctl  = {en, sz, dir, half, nullw, 5'b0, amode, 2'b0, mode};

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = ctl;
      3'd1:    reg_rdata = 16'(sta_a);
      3'd2:    reg_rdata = 16'(sta_b);
      3'd3:    reg_rdata = 16'(padr);
      3'd4:    reg_rdata = 16'(cnt);
      default: reg_rdata = '0;
    endcase
  end

  function automatic logic [15:0] fit(input logic [15:0] d);
    return sz ? {8'h00, d[7:0]} : d;
  endfunction

  assign active_buf = bsel;
  assign xfer_byte  = sz;
  assign ram_addr   = amode[1] ? per_ram_addr : cur;
  assign per_addr   = padr;
  assign ram_re     = (st == S_RD) &&  dir;
  assign per_re     = (st == S_RD) && !dir;
  assign ram_we     = (st == S_WR) && !dir;
  assign per_we     = (st == S_WR) && (dir || nullw);
  assign ram_wdata  = fit(per_rdata);
  assign per_wdata  = dir ? fit(ram_rdata) : 16'h0000;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; en <= 1'b0; sz <= 1'b0; dir <= 1'b0; half <= 1'b0;
      nullw <= 1'b0; amode <= '0; mode <= '0;
      sta_a <= '0; sta_b <= '0; padr <= '0; cnt <= '0;
      cur <= '0; done <= '0; bsel <= 1'b0; irq <= 1'b0;
    end else begin
      irq <= 1'b0;
      case (st)
        S_IDLE: if (en && xfer_req) st <= S_RD;
        S_RD:   st <= S_WR;
        default: begin
          st  <= S_IDLE;
          irq <= half ? (dn == hp) : last;
          if (last) begin
            done <= '0;
            if (mode[1]) begin
              bsel <= !bsel;
              cur  <= bsel ? sta_a : sta_b;
              if (mode[0] && bsel) en <= 1'b0;
            end else begin
              cur <= sta_a;
              if (mode[0]) en <= 1'b0;
            end
          end else begin
            done <= dn;
            if (amode == 2'b00) cur <= cur + (sz ? AW'(1) : AW'(2));
          end
        end
      endcase
      if (reg_we) begin
        case (reg_addr)
          3'd0: begin
            en <= reg_wdata[15]; sz <= reg_wdata[14]; dir <= reg_wdata[13];
            half <= reg_wdata[12]; nullw <= reg_wdata[11];
            amode <= reg_wdata[5:4]; mode <= reg_wdata[1:0];
            if (!en && reg_wdata[15]) begin
              st <= S_IDLE; done <= '0; cur <= sta_a; bsel <= 1'b0;
            end
          end
          3'd1: sta_a <= reg_wdata[AW-1:0];
          3'd2: sta_b <= reg_wdata[AW-1:0];
          3'd3: padr  <= reg_wdata[AW-1:0];
          3'd4: cnt   <= reg_wdata[CW-1:0];
          default: ;
        endcase
      end
    end
  end

  AST_OFF_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && st == S_IDLE) |=> !(ram_re || per_re)); // R2
  AST_READ_THEN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re || per_re) |=> (ram_we || per_we)); // R3
  AST_NULL_WITH_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    (per_we && !dir) |-> (ram_we && per_wdata == 16'h0000)); // R7
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq); // R8
  AST_SELF_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(en) && !$past(reg_we)) |-> $past(mode[0])); // R10
  AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_byte && ram_we) |-> (ram_wdata[15:8] == 8'h00)); // R5
endmodule

// File: tb/dma_chan_seq_bench.sv
`timescale 1ns/1ps
module dma_chan_seq_bench;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [2:0] reg_addr = 0; logic [15:0] reg_wdata = 0;
  logic [15:0] reg_rdata;
  logic xfer_req = 0, active_buf, irq, xfer_byte;
  logic [AW-1:0] ram_addr, per_addr; logic [AW-1:0] per_ram_addr = 16'h0333;
  logic ram_re, ram_we, per_re, per_we;
  logic [15:0] ram_wdata, per_wdata;
  logic [15:0] ram_rdata = 0, per_rdata = 0;
  logic [11:0] pseq = 0;
  int tests = 0, fails = 0;
  bit cdir, cbyte, cnull;
  localparam logic [15:0] PA = 16'h0040;

  always #2 clk = ~clk;

  dma_chan_seq u_dma_chan_seq (.clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .xfer_req, .active_buf, .irq, .xfer_byte, .ram_addr, .ram_re, .ram_we, .ram_wdata,
    .ram_rdata, .per_addr, .per_re, .per_we, .per_wdata, .per_rdata, .per_ram_addr);

  always_ff @(posedge clk) begin
    if (ram_re) ram_rdata <= ram_addr ^ 16'h3C3C;
    if (per_re) begin per_rdata <= {4'hB, pseq}; pseq <= pseq + 1'b1; end
  end

  task automatic check(input string tg, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tg, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rdchk(input string tg, input logic [2:0] a, input logic [15:0] exp);
    @(negedge clk); reg_addr = a; #0.5; check(tg, reg_rdata, exp);
  endtask

  function automatic logic [15:0] strb();
    return {12'b0, ram_re, per_re, ram_we, per_we};
  endfunction

  task automatic setup(input logic [15:0] a, input logic [15:0] b, input logic [15:0] c,
                       input logic [15:0] ctl);
    wr(0, 16'h0000); wr(1, a); wr(2, b); wr(3, PA); wr(4, c); wr(0, ctl);
    cdir = ctl[13]; cbyte = ctl[14]; cnull = ctl[11];
  endtask

  task automatic xfer(input string tg, input logic [15:0] ra, input bit ex_irq);
    logic [15:0] d;
    @(negedge clk); xfer_req = 1;
    @(negedge clk); xfer_req = 0;
    check({tg, " rd strobes"}, strb(), cdir ? 16'h0008 : 16'h0004);
    if (cdir) begin check({tg, " rd addr"}, ram_addr, ra); d = ra ^ 16'h3C3C; end
    else begin check({tg, " rd addr"}, per_addr, PA); d = {4'hB, pseq}; end
    if (cbyte) d = {8'h00, d[7:0]};
    @(negedge clk);
    check({tg, " wr strobes"}, strb(), cdir ? 16'h0001 : {14'b0, 1'b1, cnull});
    if (cdir) begin
      check({tg, " wr addr"}, per_addr, PA); check({tg, " wr data"}, per_wdata, d);
    end else begin
      check({tg, " wr addr"}, ram_addr, ra); check({tg, " wr data"}, ram_wdata, d);
      if (cnull) check({tg, " null data"}, per_wdata, 16'h0000);
    end
    @(negedge clk);
    check({tg, " irq"}, {15'b0, irq}, {15'b0, ex_irq});
  endtask

  task automatic t_reset();
    rdchk("R1 reset ctl", 0, 0); rdchk("R1 reset count", 4, 0);
    check("R1 reset irq/buf", {14'b0, irq, active_buf}, 0);
    wr(0, 16'h07CC); rdchk("R1 unimplemented bits", 0, 16'h0000);
    wr(0, 16'h7833); rdchk("R1 field layout", 0, 16'h7833);
    wr(1, 16'h1234); rdchk("R1 start A", 1, 16'h1234);
    wr(4, 16'h0155); rdchk("R1 count", 4, 16'h0155);
  endtask

  task automatic t_disabled();
    wr(0, 16'h0001);
    @(negedge clk); xfer_req = 1; @(negedge clk); xfer_req = 0;
    check("R2 no strobe c1", strb(), 0);
    @(negedge clk); check("R2 no strobe c2", strb(), 0);
  endtask

  task automatic t_word_rx();
    setup(16'h0100, 16'h0180, 3, 16'h8001);
    xfer("R3 w0", 16'h0100, 0); xfer("R5 w1", 16'h0102, 0);
    xfer("R5 w2", 16'h0104, 0); xfer("R8 w3", 16'h0106, 1);
    rdchk("R10 enable cleared", 0, 16'h0001);
    @(negedge clk); xfer_req = 1; @(negedge clk); xfer_req = 0;
    check("R2 after one-shot", strb(), 0);
  endtask

  task automatic t_byte_tx();
    setup(16'h0200, 0, 2, 16'hE001);
    xfer("R4 b0", 16'h0200, 0); xfer("R5 b1", 16'h0201, 0); xfer("R5 b2", 16'h0202, 1);
  endtask

  task automatic t_addr_modes();
    setup(16'h0120, 0, 1, 16'h8011);
    xfer("R6 fixed0", 16'h0120, 0); xfer("R6 fixed1", 16'h0120, 1);
    setup(16'h0120, 0, 0, 16'h8021);
    xfer("R6 periph addr", 16'h0333, 1);
    setup(16'h0120, 0, 0, 16'h8031);
    xfer("R6 mode 11", 16'h0333, 1);
  endtask

  task automatic t_half();
    setup(16'h0100, 0, 5, 16'h9001);
    xfer("R9 h0", 16'h0100, 0); xfer("R9 h1", 16'h0102, 0); xfer("R9 h2", 16'h0104, 1);
    xfer("R9 h3", 16'h0106, 0); xfer("R9 h4", 16'h0108, 0); xfer("R9 h5", 16'h010A, 0);
    setup(16'h0100, 0, 4, 16'h9001);
    xfer("R9 g0", 16'h0100, 0); xfer("R9 g1", 16'h0102, 1); xfer("R9 g2", 16'h0104, 0);
    xfer("R9 g3", 16'h0106, 0); xfer("R9 g4", 16'h0108, 0);
  endtask

  task automatic t_null();
    setup(16'h0140, 0, 0, 16'h8801);
    xfer("R7 null dir0", 16'h0140, 1);
    setup(16'h0140, 0, 0, 16'hA801);
    xfer("R7 null dir1", 16'h0140, 1);
  endtask

  task automatic t_cont();
    setup(16'h0100, 0, 1, 16'h8000);
    xfer("R11 c0", 16'h0100, 0); xfer("R11 c1", 16'h0102, 1);
    xfer("R11 reload", 16'h0100, 0); xfer("R11 c3", 16'h0102, 1);
    rdchk("R11 still enabled", 0, 16'h8000);
  endtask

  task automatic t_pingpong();
    setup(16'h0100, 16'h0180, 1, 16'h8002);
    check("R12 starts A", {15'b0, active_buf}, 0);
    xfer("R12 a0", 16'h0100, 0); xfer("R12 a1", 16'h0102, 1);
    check("R12 now B", {15'b0, active_buf}, 1);
    xfer("R12 b0", 16'h0180, 0); xfer("R12 b1", 16'h0182, 1);
    check("R12 back A", {15'b0, active_buf}, 0);
    xfer("R12 a again", 16'h0100, 0);
    setup(16'h0100, 16'h0180, 1, 16'h8003);
    xfer("R12 os a0", 16'h0100, 0); xfer("R12 os a1", 16'h0102, 1);
    rdchk("R12 enabled after A", 0, 16'h8003);
    xfer("R12 os b0", 16'h0180, 0); xfer("R12 os b1", 16'h0182, 1);
    rdchk("R12 disabled after B", 0, 16'h0003);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #9 rst_n = 1;
    t_reset(); t_disabled(); t_word_rx(); t_byte_tx(); t_addr_modes();
    t_half(); t_null(); t_cont(); t_pingpong();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule